// File: doc/BRIEF.md
# Banked Dual Stack Pointer Unit

This block keeps two 32-bit stack pointers: bank 0 serves interrupt and trap handlers, and bank 1 serves ordinary user code. A one-bit select register picks which bank is active. Each cycle the block accepts at most one push or one pop request. The request carries an operand length of one, two or four bytes. For each request that is accepted, the block returns the memory address to use and moves the active pointer. Stacks grow downward. A push decrements the pointer first and then uses the new value as the write address. A pop uses the current value as the read address and then increments the pointer.

Either pointer can be written directly, whatever the select bit holds. The select bit can be written by the surrounding control logic. Entering a trap or interrupt forces the select bit to 0, so the interrupt stack becomes active. Malformed requests produce a one-cycle error pulse and leave every pointer unchanged. All state changes take place on the rising clock edge. The access and error outputs are registered and valid for the cycle that follows the request.

Top module: `stack_ptr_bank`

## Requirements
- R1: A synchronous active-high reset clears both pointers to zero, clears the select bit, and drops the access-valid and error outputs.
- R2: With the select bit at 0, `sp_active` shows pointer 0. With the select bit at 1, it shows pointer 1. Push and pop act only on the bank chosen by the select value held before the clock edge.
- R3: An accepted push subtracts the operand length from the active pointer. In the next cycle it reports the new pointer value on `acc_addr`, with `acc_write`=1 and `acc_bank` naming the bank that was used.
- R4: An accepted pop reports the old pointer value on `acc_addr` with `acc_write`=0, and adds the operand length to the pointer.
- R5: The `len_code` input encodes the operand length as follows: 2'b00 is 1 byte, 2'b01 is 2 bytes and 2'b11 is 4 bytes.
- R6: The code 2'b10 is illegal. When a push or pop carries this code, `err` pulses for one cycle, no access is reported and neither pointer moves.
- R7: A push and a pop requested in the same cycle are rejected. `err` pulses, no access is reported and the pointers are left unchanged.
- R8: `trap_enter` clears the select bit and overrides a select write in the same cycle. A request in that cycle still uses the bank selected before the edge.
- R9: `ld0_en` and `ld1_en` load pointer 0 and pointer 1 whatever the select bit holds. A load to the active bank overrides a push or pop in the same cycle: the request is dropped without an access and without an error. A load to the other bank does not disturb the request.
- R10: Pointer arithmetic wraps modulo 2^32.
- R11: `sel_wr_en` writes `sel_wr_val` into the select bit when no trap is entered in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| len_code | input | 2 | Operand length code |
| trap_enter | input | 1 | Trap or interrupt entry; forces bank 0 |
| sel_wr_en | input | 1 | Write enable for the select bit |
| sel_wr_val | input | 1 | New select bit value |
| ld0_en | input | 1 | Load pointer 0 |
| ld0_val | input | 32 | Value loaded into pointer 0 |
| ld1_en | input | 1 | Load pointer 1 |
| ld1_val | input | 32 | Value loaded into pointer 1 |
| sel | output | 1 | Current select bit |
| sp0 | output | 32 | Interrupt stack pointer |
| sp1 | output | 32 | User stack pointer |
| sp_active | output | 32 | Pointer of the selected bank |
| acc_valid | output | 1 | An access address is valid this cycle |
| acc_write | output | 1 | 1 for a push (write), 0 for a pop (read) |
| acc_bank | output | 1 | Bank that the access used |
| acc_addr | output | 32 | Memory address of the access |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
On every cycle the assertions check the following. After a push, the used bank holds exactly the reported address. After a pop, the used bank sits 1, 2 or 4 bytes above the reported address. An error never coincides with a valid access. A push and a pop together leave both pointers stable. A trap always leaves bank 0 selected. The remaining behaviours can only be shown by the bench scenarios, because they depend on specific values: the exact length picked by each code, the choice of bank when a trap coincides with a request, load priority over a request to the same bank, and wraparound at zero and at the top of the address space.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int PTR_W  = 32;
  localparam int NBANK  = 2;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    LEN_BYTE  = 2'b00,
    LEN_WORD  = 2'b01,
    LEN_BAD   = 2'b10,
    LEN_DWORD = 2'b11
  } len_e;
endpackage

// File: rtl/stk_len_decode.sv
module stk_len_decode
  import stk_pkg::*;
#(
  parameter int AW = PTR_W
) (
  input  logic [CODE_W-1:0] code,
  output logic              legal,
  output logic [AW-1:0]     nbytes
);
  always_comb begin
    legal  = 1'b1;
    nbytes = '0;
    case (len_e'(code))
      LEN_BYTE:  nbytes = AW'(1);
      LEN_WORD:  nbytes = AW'(2);
      LEN_DWORD: nbytes = AW'(4);
      default: begin
        legal  = 1'b0;
        nbytes = '0;
      end
    endcase
  end

  // R5: a legal code always yields a single power-of-two step
  always_comb begin
    p_len_onehot_r5: assert (!legal || $onehot(nbytes));
  end
endmodule

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_val,
  input  logic          step_en,
  input  logic          step_dn,
  input  logic [AW-1:0] nbytes,
  output logic [AW-1:0] q,
  output logic [AW-1:0] q_dn
);
  assign q_dn = q - nbytes;

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (ld_en)   q <= ld_val;
    else if (step_en) q <= step_dn ? q_dn : (q + nbytes);
  end
endmodule

// File: rtl/stk_mode_reg.sv
module stk_mode_reg (
  input  logic clk,
  input  logic rst,
  input  logic trap_enter,
  input  logic wr_en,
  input  logic wr_val,
  output logic sel_q
);
  always_ff @(posedge clk) begin
    if (rst)             sel_q <= 1'b0;
    else if (trap_enter) sel_q <= 1'b0;
    else if (wr_en)      sel_q <= wr_val;
  end
endmodule

// File: rtl/stack_ptr_bank.sv
module stack_ptr_bank
  import stk_pkg::*;
#(
  parameter int AW = PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [CODE_W-1:0] len_code,
  input  logic              trap_enter,
  input  logic              sel_wr_en,
  input  logic              sel_wr_val,
  input  logic              ld0_en,
  input  logic [AW-1:0]     ld0_val,
  input  logic              ld1_en,
  input  logic [AW-1:0]     ld1_val,
  output logic              sel,
  output logic [AW-1:0]     sp0,
  output logic [AW-1:0]     sp1,
  output logic [AW-1:0]     sp_active,
  output logic              acc_valid,
  output logic              acc_write,
  output logic              acc_bank,
  output logic [AW-1:0]     acc_addr,
  output logic              err
);
  logic          legal;
  logic [AW-1:0] nbytes;
  logic [AW-1:0] sp_q  [NBANK];
  logic [AW-1:0] sp_dn [NBANK];
  logic          ld_en [NBANK];
  logic [AW-1:0] ld_val[NBANK];
  logic          step_en[NBANK];
  logic          req, bad, act_ld, go;

  stk_len_decode #(.AW(AW)) u_len (
    .code(len_code), .legal(legal), .nbytes(nbytes)
  );

  stk_mode_reg u_mode (
    .clk(clk), .rst(rst), .trap_enter(trap_enter),
    .wr_en(sel_wr_en), .wr_val(sel_wr_val), .sel_q(sel)
  );

  assign ld_en[0]  = ld0_en;
  assign ld_en[1]  = ld1_en;
  assign ld_val[0] = ld0_val;
  assign ld_val[1] = ld1_val;

  assign req    = push_req | pop_req;
  assign bad    = req & ((push_req & pop_req) | ~legal);
  assign act_ld = ld_en[sel];
  assign go     = req & ~bad & ~act_ld;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign step_en[b] = go & (sel == 1'(b));
    stk_ptr_reg #(.AW(AW)) u_ptr (
      .clk(clk), .rst(rst),
      .ld_en(ld_en[b]), .ld_val(ld_val[b]),
      .step_en(step_en[b]), .step_dn(push_req),
      .nbytes(nbytes), .q(sp_q[b]), .q_dn(sp_dn[b])
    );
  end

  assign sp0       = sp_q[0];
  assign sp1       = sp_q[1];
  assign sp_active = sp_q[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid <= 1'b0;
      acc_write <= 1'b0;
      acc_bank  <= 1'b0;
      acc_addr  <= '0;
      err       <= 1'b0;
    end else begin
      acc_valid <= go;
      err       <= bad;
      if (go) begin
        acc_write <= push_req;
        acc_bank  <= sel;
        acc_addr  <= push_req ? sp_dn[sel] : sp_q[sel];
      end
    end
  end

  // R3: after a push the used bank holds exactly the write address
  p_push_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write) |-> ((acc_bank ? sp1 : sp0) == acc_addr));

  // R4: after a pop the used bank sits one legal length above the read address
  p_pop_step_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |->
      ((acc_bank ? sp1 : sp0) - acc_addr == AW'(1) ||
       (acc_bank ? sp1 : sp0) - acc_addr == AW'(2) ||
       (acc_bank ? sp1 : sp0) - acc_addr == AW'(4)));

  // R6: a rejection never comes with an access
  p_err_excl_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> !acc_valid);

  // R7: a push and a pop together are refused and nothing moves
  p_dual_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(push_req && pop_req && !ld0_en && !ld1_en))
      |-> (err && $stable(sp0) && $stable(sp1)));

  // R8: trap entry always leaves the interrupt bank selected
  p_trap_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(trap_enter)) |-> !sel);
endmodule

// File: tb/sim_stack_ptr_bank.sv
`timescale 1ns/1ps
module sim_stack_ptr_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic        push_req, pop_req, trap_enter, sel_wr_en, sel_wr_val;
  logic [1:0]  len_code;
  logic        ld0_en, ld1_en;
  logic [31:0] ld0_val, ld1_val;
  logic        sel, acc_valid, acc_write, acc_bank, err;
  logic [31:0] sp0, sp1, sp_active, acc_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_sp[2];
  logic        m_sel, m_valid, m_write, m_bank, m_err;
  logic [31:0] m_addr;

  always #2 clk = ~clk;

  stack_ptr_bank u0 (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .len_code(len_code), .trap_enter(trap_enter), .sel_wr_en(sel_wr_en),
    .sel_wr_val(sel_wr_val), .ld0_en(ld0_en), .ld0_val(ld0_val),
    .ld1_en(ld1_en), .ld1_val(ld1_val), .sel(sel), .sp0(sp0), .sp1(sp1),
    .sp_active(sp_active), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_bank(acc_bank), .acc_addr(acc_addr), .err(err)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one clock: drive, advance the model, compare after the edge
  task automatic step(input string tag, input logic r, input logic p,
                      input logic po, input logic [1:0] l, input logic t,
                      input logic sw, input logic sv, input logic l0,
                      input logic [31:0] v0, input logic l1,
                      input logic [31:0] v1);
    int n;
    logic legal, req, bad, blk, b;
    rst = r; push_req = p; pop_req = po; len_code = l; trap_enter = t;
    sel_wr_en = sw; sel_wr_val = sv; ld0_en = l0; ld0_val = v0;
    ld1_en = l1; ld1_val = v1;
    // R5 lengths
    n = (l == 2'b00) ? 1 : (l == 2'b01) ? 2 : (l == 2'b11) ? 4 : 0;
    legal = (l != 2'b10);
    req = p | po;
    bad = req && ((p && po) || !legal);
    b = m_sel;
    blk = b ? l1 : l0;
    if (r) begin
      m_sp[0] = 0; m_sp[1] = 0; m_sel = 0; m_valid = 0; m_err = 0;
    end else begin
      m_err = bad;
      m_valid = req && !bad && !blk;
      if (m_valid) begin
        m_write = p; m_bank = b;
        if (p) begin m_sp[b] = m_sp[b] - 32'(n); m_addr = m_sp[b]; end
        else begin m_addr = m_sp[b]; m_sp[b] = m_sp[b] + 32'(n); end
      end
      if (l0) m_sp[0] = v0;
      if (l1) m_sp[1] = v1;
      if (t) m_sel = 0;
      else if (sw) m_sel = sv;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "sel", 32'(sel), 32'(m_sel));
    chk(tag, "sp0", sp0, m_sp[0]);
    chk(tag, "sp1", sp1, m_sp[1]);
    chk(tag, "sp_active", sp_active, m_sp[m_sel]);
    chk(tag, "acc_valid", 32'(acc_valid), 32'(m_valid));
    chk(tag, "err", 32'(err), 32'(m_err));
    if (m_valid) begin
      chk(tag, "acc_write", 32'(acc_write), 32'(m_write));
      chk(tag, "acc_bank", 32'(acc_bank), 32'(m_bank));
      chk(tag, "acc_addr", acc_addr, m_addr);
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 2'b00, 0, 0, 0, 0, 32'h0, 0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    @(negedge clk);
    // R1 reset, from a dirty state
    step("R1", 1, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 2'b00, 0, 1, 1, 1, 32'h55, 1, 32'h66);
    step("R1", 1, 1, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    // R10 push word from zero wraps; R3
    step("R10", 0, 1, 0, 2'b01, 0, 0, 0, 0, 0, 0, 0);
    // R9 load bank 1 while bank 0 active; R11 select bank 1
    step("R9", 0, 0, 0, 2'b00, 0, 1, 1, 0, 0, 1, 32'h1000);
    // R3/R4/R5 on bank 1, R2 active view
    step("R3", 0, 1, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 1, 0, 2'b11, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 0, 1, 0, 2'b01, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 1, 2'b01, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 1, 2'b11, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 1, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    // R6 illegal code, push and pop
    step("R6", 0, 1, 0, 2'b10, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 2'b10, 0, 0, 0, 0, 0, 0, 0);
    idle("R6");
    // R7 push and pop together
    step("R7", 0, 1, 1, 2'b11, 0, 0, 0, 0, 0, 0, 0);
    idle("R7");
    // R8 trap with a push: push uses bank 1, then bank 0 is active
    step("R8", 0, 1, 0, 2'b11, 1, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 1, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    // R8 trap overrides a select write
    step("R11", 0, 0, 0, 2'b00, 0, 1, 1, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 2'b00, 1, 1, 1, 0, 0, 0, 0);
    // R9 load to active bank wins over push; other bank load is harmless
    step("R9", 0, 1, 0, 2'b11, 0, 0, 0, 1, 32'h2000, 0, 0);
    step("R9", 0, 0, 1, 2'b11, 0, 0, 0, 1, 32'h3000, 0, 0);
    step("R9", 0, 1, 0, 2'b01, 0, 0, 0, 0, 0, 1, 32'h4444);
    // R10 pop wraps past the top
    step("R10", 0, 0, 0, 2'b00, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
    step("R10", 0, 0, 1, 2'b11, 0, 0, 0, 0, 0, 0, 0);
    // mixed traffic, R2
    for (int i = 0; i < 400; i++) begin
      step("R2", 0, $urandom % 2 == 0, $urandom % 3 == 0, 2'($urandom),
           $urandom % 9 == 0, $urandom % 5 == 0, 1'($urandom),
           $urandom % 11 == 0, $urandom, $urandom % 11 == 0, $urandom);
    end
    step("R1", 1, 0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 0);
    summary();
  end
endmodule